// File: doc/BRIEF.md
# Secondary Interrupt Controller with Direct Line Routing

This block collects 32 level-sensitive interrupt sources, registers them each clock, and reduces the enabled ones to a single combined request meant for one input of a primary vectored controller (line 31 by convention). A software-settable flag is merged into source 0 so firmware can raise an interrupt by itself.

A window of sources, bits 21 to 30 by default, can also be routed around the enable mask. When the routing enable for such a bit is set, the matching output line follows the registered source level directly. Software sees a 32-bit register port with a 4 KB window, decoded by word index (address bits [11:2]). The set and clear registers use write-one semantics.

The register decode is a named enumeration of word indices handled by one `unique case` per direction. The defined indices are STATUS (0), RAW (1), ENABLE (2, set on write), ENCLR (3), SOFTSET (4), SOFTCLR (5), ROUTE (8, set on write) and ROUTECLR (9). Every other index is an idle decode. There are no sequential states, so no transitions exist.

Top module: `sic_top`

## Requirements
- R1: Raw level bit i equals `src_i[i]` as sampled on the previous rising clock edge. Bit 0 is additionally ORed with the software flag.
- R2: `irq_o` is high exactly when the raw level ANDed with the enable mask is nonzero.
- R3: Reads are combinational on `bus_addr[11:2]`. Index 0 returns raw AND mask, index 1 returns the raw level, index 2 returns the mask, and index 8 returns the routing enables.
- R4: A write (`bus_sel` and `bus_wr` high at a rising edge) to index 2 ORs `bus_wdata` into the mask, visible from the next cycle.
- R5: A write to index 3 clears every mask bit that is 1 in `bus_wdata`.
- R6: A nonzero write to index 4 sets the software flag, and a nonzero write to index 5 clears it. A zero write to either leaves the flag unchanged. Index 4 reads as raw bit 0 in bit 0, with zeros above.
- R7: A write to index 8 ORs in `bus_wdata & 32'h7FE00000`. A write to index 9 clears every routing enable bit written as 1.
- R8: For i in 21..30, `pt_o[i]` is the raw level bit i AND routing enable bit i, with no mask applied. All other `pt_o` bits are 0.
- R9: Reads of undefined indices return 0. Writes to undefined indices leave the mask, the routing enables and the software flag unchanged.
- R10: Reset (active-low `rst_n`) clears the mask, the routing enables, the software flag and the sampled levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | 32 | Interrupt source levels |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address within the 4 KB window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| irq_o | output | 1 | Combined masked request to the primary controller |
| pt_o | output | 32 | Routed lines to the primary controller (bits 21..30 active) |

## Verification
Random source vectors combined with random set and clear patterns tell a correct mask apart from an inverted or ignored one. They also separate `irq_o` from a plain OR of the sources. Writing all-ones to the routing set register exposes leakage outside bits 21..30. Routing a source whose mask bit is clear shows that the routed lines bypass the mask. Zero-valued writes to the soft set and clear indices, together with writes to gap indices such as 6, 7 and 10, separate "nonzero only" and "defined only" decoding from looser decoders.

// File: rtl/sic_pkg.sv
package sic_pkg;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 12;
    localparam int IDX_W  = ADDR_W - 2;

    typedef enum logic [IDX_W-1:0] {
        W_STATUS   = 10'd0,
        W_RAW      = 10'd1,
        W_ENABLE   = 10'd2,
        W_ENCLR    = 10'd3,
        W_SOFTSET  = 10'd4,
        W_SOFTCLR  = 10'd5,
        W_ROUTE    = 10'd8,
        W_ROUTECLR = 10'd9
    } widx_e;
endpackage

// File: rtl/sic_level.sv
module sic_level
    import sic_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] src_i,
    input  logic              soft_q,
    output logic [DATA_W-1:0] raw_o
);
    logic [DATA_W-1:0] level_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) level_q <= '0;
        else        level_q <= src_i;
    end

    assign raw_o = {level_q[DATA_W-1:1], level_q[0] | soft_q};

    // R1: each upper raw bit is last cycle's source level
    a_r1_sample: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> raw_o[DATA_W-1:1] == $past(src_i[DATA_W-1:1]));
endmodule

// File: rtl/sic_regs.sv
module sic_regs
    import sic_pkg::*;
#(
    parameter logic [DATA_W-1:0] PT_WIN = 32'h7FE0_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] mask_q,
    output logic [DATA_W-1:0] pten_q,
    output logic              soft_q
);
    widx_e             widx;
    logic              wr_en;
    logic              wnz;
    logic [DATA_W-1:0] mask_d;
    logic [DATA_W-1:0] pten_d;
    logic              soft_d;

    assign widx  = widx_e'(bus_addr[ADDR_W-1:2]);
    assign wr_en = bus_sel & bus_wr;
    assign wnz   = |bus_wdata;

    always_comb begin
        mask_d = mask_q;
        pten_d = pten_q;
        soft_d = soft_q;
        if (wr_en) begin
            unique case (widx)
                W_ENABLE:   mask_d = mask_q | bus_wdata;
                W_ENCLR:    mask_d = mask_q & ~bus_wdata;
                W_SOFTSET:  if (wnz) soft_d = 1'b1;
                W_SOFTCLR:  if (wnz) soft_d = 1'b0;
                W_ROUTE:    pten_d = pten_q | (bus_wdata & PT_WIN);
                W_ROUTECLR: pten_d = pten_q & ~bus_wdata;
                default:    ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '0;
            pten_q <= '0;
            soft_q <= 1'b0;
        end else begin
            mask_q <= mask_d;
            pten_q <= pten_d;
            soft_q <= soft_d;
        end
    end

    a_r4_set_or: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && widx == W_ENABLE) |=> ((mask_q & $past(bus_wdata)) == $past(bus_wdata)));
    a_r5_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && widx == W_ENCLR) |=> ((mask_q & $past(bus_wdata)) == '0));
    a_r6_zero_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wnz && (widx == W_SOFTSET || widx == W_SOFTCLR)) |=> $stable(soft_q));
    a_r7_window: assert property (@(posedge clk) disable iff (!rst_n)
        (pten_q & ~PT_WIN) == '0);
    a_r9_undef_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !(widx inside {W_ENABLE, W_ENCLR, W_SOFTSET, W_SOFTCLR, W_ROUTE, W_ROUTECLR}))
        |=> ($stable(mask_q) && $stable(pten_q) && $stable(soft_q)));
endmodule

// File: rtl/sic_route.sv
module sic_route
    import sic_pkg::*;
#(
    parameter int PT_LO = 21,
    parameter int PT_HI = 30
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] raw_i,
    input  logic [DATA_W-1:0] mask_i,
    input  logic [DATA_W-1:0] pten_i,
    input  logic              soft_i,
    input  logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_o,
    output logic [DATA_W-1:0] pt_o
);
    logic [DATA_W-1:0] status;
    widx_e             ridx;

    assign status = raw_i & mask_i;
    assign irq_o  = |status;
    assign ridx   = widx_e'(bus_addr[ADDR_W-1:2]);

    for (genvar i = 0; i < DATA_W; i++) begin : g_pt
        if (i >= PT_LO && i <= PT_HI) begin : g_on
            assign pt_o[i] = raw_i[i] & pten_i[i];
        end else begin : g_off
            assign pt_o[i] = 1'b0;
        end
    end

    always_comb begin
        unique case (ridx)
            W_STATUS:  bus_rdata = status;
            W_RAW:     bus_rdata = raw_i;
            W_ENABLE:  bus_rdata = mask_i;
            W_SOFTSET: bus_rdata = {{(DATA_W-1){1'b0}}, raw_i[0]};
            W_ROUTE:   bus_rdata = pten_i;
            default:   bus_rdata = '0;
        endcase
    end

    // R1: a set software flag always shows in raw bit 0
    a_r1_soft_merge: assert property (@(posedge clk) disable iff (!rst_n)
        soft_i |-> raw_i[0]);
    // R8: a routed line never fires without its routing enable
    a_r8_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (pt_o & ~pten_i) == '0);
endmodule

// File: rtl/sic_top.sv
module sic_top
    import sic_pkg::*;
#(
    parameter int PT_LO = 21,
    parameter int PT_HI = 30
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [31:0] src_i,
    input  logic        bus_sel,
    input  logic        bus_wr,
    input  logic [11:0] bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        irq_o,
    output logic [31:0] pt_o
);
    localparam logic [DATA_W:0] HI_ONES = (33'd1 << (PT_HI + 1)) - 33'd1;
    localparam logic [DATA_W:0] LO_ONES = (33'd1 << PT_LO) - 33'd1;
    localparam logic [DATA_W-1:0] PT_WIN = DATA_W'(HI_ONES & ~LO_ONES);

    logic [DATA_W-1:0] mask_q;
    logic [DATA_W-1:0] pten_q;
    logic              soft_q;
    logic [DATA_W-1:0] raw;

    sic_regs #(.PT_WIN(PT_WIN)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .mask_q(mask_q), .pten_q(pten_q), .soft_q(soft_q)
    );

    sic_level u_level (
        .clk(clk), .rst_n(rst_n), .src_i(src_i), .soft_q(soft_q), .raw_o(raw)
    );

    sic_route #(.PT_LO(PT_LO), .PT_HI(PT_HI)) u_route (
        .clk(clk), .rst_n(rst_n), .raw_i(raw), .mask_i(mask_q), .pten_i(pten_q),
        .soft_i(soft_q), .bus_addr(bus_addr), .bus_rdata(bus_rdata),
        .irq_o(irq_o), .pt_o(pt_o)
    );

    // R2: no request while the mask is empty
    a_r2_empty_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == '0) |-> !irq_o);
    // R10: registers come out of reset cleared
    a_r10_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (mask_q == '0 && pten_q == '0 && !soft_q));
endmodule

// File: tb/tb_sic_top.sv
module tb_sic_top;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] WIN = 32'h7FE0_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src_i = '0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_o;
    logic [31:0] pt_o;

    int nchk = 0;
    int nbad = 0;
    bit done = 1'b0;

    logic [31:0] m_lvl = '0, m_mask = '0, m_pten = '0;
    logic        m_soft = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sic_top dut (.*);

    function automatic logic [31:0] m_raw();
        return {m_lvl[31:1], m_lvl[0] | m_soft};
    endfunction

    function automatic logic [31:0] m_read(int idx);
        case (idx)
            0: return m_raw() & m_mask;
            1: return m_raw();
            2: return m_mask;
            4: return {31'b0, m_raw()[0]};
            8: return m_pten;
            default: return 32'h0;
        endcase
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // one clock: drive source and an optional write, update model, check outputs
    task automatic cyc(logic [31:0] src, bit wr, int idx, logic [31:0] wd);
        @(negedge clk);
        src_i = src; bus_sel = wr; bus_wr = wr;
        bus_addr = 12'(idx << 2); bus_wdata = wd;
        @(posedge clk);
        m_lvl = src;
        if (wr) begin
            case (idx)
                2: m_mask = m_mask | wd;
                3: m_mask = m_mask & ~wd;
                4: if (wd != 0) m_soft = 1'b1;
                5: if (wd != 0) m_soft = 1'b0;
                8: m_pten = m_pten | (wd & WIN);
                9: m_pten = m_pten & ~wd;
                default: ;
            endcase
        end
        #1;
        bus_sel = 1'b0; bus_wr = 1'b0;
        chk("R2 irq", {31'b0, irq_o}, {31'b0, |(m_raw() & m_mask)});
        chk("R8 pt", pt_o, m_raw() & m_pten & WIN);
    endtask

    task automatic rd(string req, int idx);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 12'(idx << 2);
        #1;
        chk(req, bus_rdata, m_read(idx));
        bus_sel = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            nbad++;
            $display("FAIL watchdog: actual running expected done");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        #1;
        // R10 reset state
        chk("R10 irq", {31'b0, irq_o}, 32'h0);
        rd("R10 mask", 2);
        rd("R10 route", 8);
        rd("R10 soft", 4);
        @(negedge clk) rst_n = 1'b1;

        // R1 sampling, R3 raw read
        cyc(32'hA5A5_0F0E, 0, 0, 0);
        rd("R1 raw", 1);
        rd("R3 status", 0);
        // R4/R5 mask set then clear
        cyc(32'hFFFF_FFFE, 1, 2, 32'h0000_F00F);
        rd("R4 mask", 2);
        rd("R3 status", 0);
        cyc(32'hFFFF_FFFE, 1, 3, 32'h0000_000F);
        rd("R5 mask", 2);
        // R6 soft flag: zero writes no effect
        cyc(32'h0, 1, 4, 32'h0);
        rd("R6 zero set", 4);
        cyc(32'h0, 1, 4, 32'h8000_0000);
        rd("R6 soft set", 4);
        cyc(32'h0, 1, 2, 32'h1);
        chk("R6 soft irq", {31'b0, irq_o}, 32'h1);
        cyc(32'h0, 1, 5, 32'h0);
        rd("R6 zero clr", 4);
        cyc(32'h0, 1, 5, 32'h2);
        rd("R6 soft clr", 4);
        // R7 window limit, R8 bypasses mask
        cyc(32'h0, 1, 3, 32'hFFFF_FFFF);
        cyc(32'hFFFF_FFFF, 1, 8, 32'hFFFF_FFFF);
        rd("R7 route set", 8);
        chk("R8 unmasked", pt_o, WIN);
        chk("R2 mask empty", {31'b0, irq_o}, 32'h0);
        cyc(32'hFFFF_FFFF, 1, 9, 32'h0020_0000);
        rd("R7 route clr", 8);
        // R9 undefined indices
        cyc(32'h1234_5678, 1, 6, 32'hFFFF_FFFF);
        cyc(32'h1234_5678, 1, 7, 32'hFFFF_FFFF);
        cyc(32'h1234_5678, 1, 10, 32'hFFFF_FFFF);
        cyc(32'h1234_5678, 1, 1023, 32'hFFFF_FFFF);
        rd("R9 mask kept", 2);
        rd("R9 route kept", 8);
        rd("R9 soft kept", 4);
        rd("R9 undef read", 6);
        rd("R9 undef read", 3);
        rd("R9 undef read", 12);

        // random mix
        for (int n = 0; n < 600; n++) begin
            int pick = $urandom_range(0, 15);
            int idx = (pick < 12) ? pick : $urandom_range(0, 1023);
            logic [31:0] wd = ($urandom_range(0, 3) == 0) ? 32'h0 : 32'($urandom);
            cyc(32'($urandom), $urandom_range(0, 1) == 1, idx, wd);
            rd("R3 random read", $urandom_range(0, 10));
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
        $finish;
    end
endmodule